// File: doc/BRIEF.md
# Zero-Wait Read Wrapper for a Synchronous RAM

This block puts a synchronous RAM, whose read is registered, in the place of an asynchronous RAM without adding a cycle of read latency. The surrounding logic computes the next address in one cycle and uses the memory in the following cycle. The wrapper starts the read from that next address, before the address register has captured it. As a result, read data is already valid in the cycle where the access logically takes place.

A read is issued on every clock, because the access decode arrives too late to gate it. A write needs a write enable that arrives late in the access cycle. The write always lands at the address already held in the register, never at the next address.

The parameter `DUAL` picks one of two structures:

- **Dual-port (`DUAL=1`):** a read-only port follows the lookahead address and a write-only port follows the registered address.
- **Single-port (`DUAL=0`):** the RAM's own address register is the address register. It is held during a write, and an address update that arrives during a write is applied one cycle late.

A location written on one edge and read back from the next edge is not forwarded by the dual-port variant. Reads and writes are treated as separate operations, so that read returns unspecified data.

Top module: `lookahead_sram`

## Requirements
- R1: After reset the registered address is 0, so once the memory has been written, the read data shows word 0.
- R2: When `addr_upd` is high at an edge that takes the update, the read data in the very next cycle equals the word at `addr_next` (no extra latency). In single-port mode this applies only when `wr_en` is low at that edge.
- R3: When `addr_upd` is low and no update is deferred, the address holds and the read data keeps showing the same word, whatever `addr_next` carries.
- R4: A write with `wr_en` high stores `wr_data` at the current registered address, and `addr_next` has no effect on where it lands.
- R5: `wr_en` is ignored while `rst_n` is low, so memory contents are unchanged by a write attempted in reset.
- R6: In single-port mode (`DUAL=0`), an edge with both `wr_en` and `addr_upd` high writes at the held address and keeps the address. The deferred update is applied at the next edge without `wr_en`.
- R7: In single-port mode, a deferred update is replaced by any newer `addr_upd`. A further write edge keeps the update deferred.
- R8: In dual-port mode (`DUAL=1`), a write and an address update on the same edge both take effect: the write goes to the old address and the address moves to `addr_next`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the address state |
| addr_next | input | AW = log2(DEPTH) | Next value for the address register |
| addr_upd | input | 1 | Load `addr_next` into the address register |
| wr_en | input | 1 | Late write enable for the current address |
| wr_data | input | DW | Data to write |
| rd_data | output | DW | Word at the registered address |

## Verification
The bench builds two instances side by side, one with `DUAL=1` and one with `DUAL=0`, each with an 8-bit word and 16 locations. The small depth makes random traffic revisit the same words often. This exposes writes that land at the lookahead address instead of the held one, as well as stale read data after an update. Running both variants on identical stimulus also shows how the deferred-update rule makes their address sequences diverge and then rejoin.

// File: rtl/lookahead_sram.sv
module lookahead_sram #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  parameter bit DUAL  = 1'b1,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_next,
  input  logic          addr_upd,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);

  logic [AW-1:0] a_q;
  logic          pend_v;

  generate
    if (DUAL) begin : g_dual
      logic [DW-1:0] mem [DEPTH];
      logic [DW-1:0] rd_q;
      logic [AW-1:0] look_a;

      assign look_a = !rst_n ? '0 : (addr_upd ? addr_next : a_q);
      assign pend_v = 1'b0;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        a_q <= '0;
        else if (addr_upd) a_q <= addr_next;

      always_ff @(posedge clk) begin
        if (wr_en && rst_n) mem[a_q] <= wr_data;
        rd_q <= mem[look_a];
      end

      assign rd_data = rd_q;
    end else begin : g_single
      logic [DW-1:0] mem [DEPTH];
      logic [AW-1:0] pend_a;
      logic          pend_q;

      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          a_q    <= '0;
          pend_q <= 1'b0;
          pend_a <= '0;
        end else if (wr_en) begin
          if (addr_upd) begin
            pend_q <= 1'b1;
            pend_a <= addr_next;
          end
        end else if (addr_upd) begin
          a_q    <= addr_next;
          pend_q <= 1'b0;
        end else if (pend_q) begin
          a_q    <= pend_a;
          pend_q <= 1'b0;
        end

      always_ff @(posedge clk)
        if (wr_en && rst_n) mem[a_q] <= wr_data;

      assign pend_v  = pend_q;
      assign rd_data = mem[a_q];
    end
  endgenerate

endmodule

module lookahead_sram_chk #(
  parameter int AW   = 10,
  parameter bit DUAL = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_next,
  input logic          addr_upd,
  input logic          wr_en,
  input logic [AW-1:0] a_q,
  input logic          pend_v
);

  p_reset_addr_r1: assert property (@(posedge clk)
    !rst_n |-> (a_q == '0 && !pend_v));

  p_update_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_upd && (DUAL || !wr_en)) |=> a_q == $past(addr_next));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_upd && !pend_v) |=> $stable(a_q));

  p_write_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!DUAL && wr_en) |=> $stable(a_q));

  p_defer_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!DUAL && wr_en && addr_upd) |=> pend_v);

  p_defer_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !wr_en && !addr_upd) |=> !pend_v);

  p_dual_no_defer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    DUAL |-> !pend_v);

endmodule

bind lookahead_sram lookahead_sram_chk #(.AW(AW), .DUAL(DUAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_next(addr_next), .addr_upd(addr_upd),
  .wr_en(wr_en), .a_q(a_q), .pend_v(pend_v)
);

// File: tb/test_lookahead_sram.sv
`timescale 1ns/1ps
module test_lookahead_sram;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, upd = 1'b0, we = 1'b0;
  logic [AW-1:0] an = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rd_dp, rd_sp;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [DW-1:0] mm [2][DEPTH];
  int ma [2];
  int pa [2];
  bit pv [2];
  bit ex [2];

  always #10 clk = ~clk;

  lookahead_sram #(.DW(DW), .DEPTH(DEPTH), .DUAL(1'b1)) i_lookahead_sram (
    .clk(clk), .rst_n(rst_n), .addr_next(an), .addr_upd(upd),
    .wr_en(we), .wr_data(wd), .rd_data(rd_dp));

  lookahead_sram #(.DW(DW), .DEPTH(DEPTH), .DUAL(1'b0)) i_lookahead_sram_sp (
    .clk(clk), .rst_n(rst_n), .addr_next(an), .addr_upd(upd),
    .wr_en(we), .wr_data(wd), .rd_data(rd_sp));

  task automatic compare(string tag);
    for (int k = 0; k < 2; k++) begin
      logic [DW-1:0] exp, got;
      exp = mm[k][ma[k]];
      got = (k == 0) ? rd_dp : rd_sp;
      if (!ex[k] && !$isunknown(exp)) begin
        checks++;
        if (got !== exp) begin
          fails++;
          $display("FAIL %s %s addr %0d: got %h expected %h",
                   tag, (k == 0) ? "dual" : "single", ma[k], got, exp);
        end
      end
    end
  endtask

  task automatic model_edge();
    for (int k = 0; k < 2; k++) begin
      int old_a;
      old_a = ma[k];
      if (k == 0) begin
        if (we) mm[k][old_a] = wd;
        if (upd) ma[k] = int'(an);
        ex[k] = we && (ma[k] == old_a);
      end else begin
        ex[k] = 1'b0;
        if (we) begin
          mm[k][old_a] = wd;
          if (upd) begin pv[k] = 1'b1; pa[k] = int'(an); end
        end else if (upd) begin
          ma[k] = int'(an); pv[k] = 1'b0;
        end else if (pv[k]) begin
          ma[k] = pa[k]; pv[k] = 1'b0;
        end
      end
    end
  endtask

  task automatic step(bit u, int a, bit w, int d, string tag);
    upd = u; an = AW'(a); we = w; wd = DW'(d);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 1'b0; upd = 1'b1; an = AW'(3); we = 1'b1; wd = 8'hEE;
    for (int k = 0; k < 2; k++) begin ma[k] = 0; pv[k] = 1'b0; ex[k] = 1'b0; end
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1; upd = 1'b0; we = 1'b0;
    #1 compare(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < DEPTH; i++) mm[k][i] = 'x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, i, 1'b0, 0, "R2");
      step(1'b0, 0, 1'b1, (i * 37 + 5) & 8'hFF, "R4");
    end
    do_reset("R1/R5");
    step(1'b0, 0, 1'b0, 0, "R1");
    step(1'b1, 5, 1'b0, 0, "R2");
    step(1'b0, 0, 1'b0, 0, "R3");
    step(1'b0, 9, 1'b0, 0, "R3");
    step(1'b0, 11, 1'b1, 8'h5A, "R4");
    step(1'b1, 2, 1'b0, 0, "R4");
    step(1'b1, 11, 1'b0, 0, "R4");
    step(1'b1, 5, 1'b0, 0, "R4");
    step(1'b1, 7, 1'b0, 0, "R2");
    step(1'b1, 9, 1'b1, 8'hC3, "R6/R8");
    step(1'b0, 0, 1'b0, 0, "R6/R8");
    step(1'b1, 7, 1'b0, 0, "R8");
    step(1'b1, 3, 1'b1, 8'h11, "R7");
    step(1'b1, 12, 1'b0, 0, "R7");
    step(1'b0, 0, 1'b0, 0, "R7");
    step(1'b1, 4, 1'b1, 8'h22, "R7");
    step(1'b0, 0, 1'b1, 8'h33, "R7");
    step(1'b0, 0, 1'b0, 0, "R7");
    step(1'b1, 12, 1'b0, 0, "R7");
    do_reset("R5");
    for (int n = 0; n < 600; n++)
      step($urandom_range(0, 1) == 1, $urandom_range(0, DEPTH - 1),
           $urandom_range(0, 2) == 0, $urandom_range(0, 255), "R2/R4");
    do_reset("R1");
    finish_run();
  end
endmodule